// File: doc/BRIEF.md
# Chainable PWM Timer with Trigger Modes

This block is a general-purpose up-counter that drives a parameterised set of PWM channels from one shared period, and that can be linked to other timers through a single trigger line in each direction. One selector decides which internal event leaves the block on the trigger output. A slave controller decides how the incoming trigger acts on the counter: it can gate the counting, start it once, or replace the internal prescaled clock altogether.

Software configures the block through a plain register-write port. The port carries the prescaler, the period limit (reload), one compare value per channel, the master and slave selects and per-channel enables. Period, prescaler and compare values are double-buffered, so a new setting never produces a shortened or glitched cycle. A typical use is a chain of two instances. The first instance drives its channel-0 reference out as its trigger. The second instance runs in gated mode, so its outputs pulse only while the first instance's waveform is high.

The configuration port is a register write, not a data stream, so it has no valid/ready handshake. A write is accepted in every cycle that `cfg_we` is high, and no back-pressure exists.

Top module: `chain_pwm_timer`

## Requirements
- R1: After reset every PWM output and the trigger output are low, the run bit is clear and the counter is 0.
- R2: While running, the counter steps from 0 up to the active reload value and then returns to 0. Each return raises a one-cycle update pulse. With prescaler P and reload A the period is (P+1)*(A+1) clocks.
- R3: A channel output is high while the counter is below that channel's compare value and low otherwise. A compare value of 0 gives a constant low output. A compare value above the reload value gives a constant high output.
- R4: Writes to the prescaler, reload and compare registers go to shadow copies. The shadow copies take effect at the next update pulse, or at once while the run bit is clear.
- R5: Control register bits [5+k] enable channel k. A disabled channel stays low, and while the run bit (control bit 0) is clear every output is low and the counter is held at 0.
- R6: Control bits [4:3] choose the trigger output: 0 gives the counter-enable state, 1 gives the update pulse, 2 gives the channel-0 compare reference, and 3 gives a constant low.
- R7: Control bits [2:1] equal to 1 select gated mode. In this mode the prescaler and counter advance only while the synchronised trigger is high, and hold otherwise. The channel outputs are low while the gate is closed.
- R8: Slave select 2 selects trigger-start mode. In this mode the counter stays stopped and the outputs stay low until the first rising edge of the synchronised trigger after the run bit is set. From then on the counter runs freely.
- R9: Slave select 3 selects external-clock mode. In this mode the counter advances once per rising edge of the synchronised trigger, and the prescaler has no effect. Slave select 0 runs the counter freely from the prescaler.
- R10: The trigger input passes through a two-flop synchroniser. A level change at the pin reaches the gate logic two clocks later.
- R11: The counter width is a build parameter of 16 or 32 bits, and reload and compare values use the full width.
- R12: The register addresses are 0 for control, 1 for prescaler, 2 for reload, and 3+k for the compare value of channel k.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | ADDR_W | Register address |
| cfg_wdata | input | 32 | Register write data |
| trig_in | input | 1 | Trigger from another timer (asynchronous) |
| trig_out | output | 1 | Trigger selected by master mode |
| pwm_out | output | NUM_CH | Channel PWM outputs |

## Verification
The bench builds the block with a 32-bit counter, four channels and a 16-bit prescaler. The 32-bit width lets it program a reload of 70000 and a compare of 66000, values a 16-bit counter would truncate, so one long period checks the full-width compare path. With four channels the first and last channels and a masked channel can be checked in the same run. The short periods in the vector table also cover a compare of zero, a compare above the reload value and a compare equal to reload+1.

// File: rtl/cpt_pkg.sv
package cpt_pkg;
  typedef enum logic [1:0] {
    SLV_FREE   = 2'd0,
    SLV_GATED  = 2'd1,
    SLV_TRIG   = 2'd2,
    SLV_EXTCLK = 2'd3
  } slave_mode_e;

  typedef enum logic [1:0] {
    MST_ENABLE = 2'd0,
    MST_UPDATE = 2'd1,
    MST_CMP1   = 2'd2,
    MST_NONE   = 2'd3
  } master_mode_e;

  localparam int CFG_DATA_W    = 32;
  localparam int ADDR_CTRL     = 0;
  localparam int ADDR_PSC      = 1;
  localparam int ADDR_ARR      = 2;
  localparam int ADDR_CMP_BASE = 3;

  localparam int CTRL_RUN_BIT  = 0;
  localparam int CTRL_SLV_LSB  = 1;
  localparam int CTRL_MST_LSB  = 3;
  localparam int CTRL_CHEN_LSB = 5;
endpackage

// File: rtl/cpt_trig_sync.sv
module cpt_trig_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  output logic level,
  output logic rise
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], trig_in};
      prev_q <= sync_q[STAGES-1];
    end
  end

  assign level = sync_q[STAGES-1];
  assign rise  = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/cpt_regfile.sv
module cpt_regfile
  import cpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int PSC_W  = 16,
  parameter int NUM_CH = 4,
  parameter int ADDR_W = 3
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          cfg_we,
  input  logic [ADDR_W-1:0]             cfg_addr,
  input  logic [CFG_DATA_W-1:0]         cfg_wdata,
  input  logic                          load_act,
  output logic                          run_en,
  output slave_mode_e                   slave_mode,
  output master_mode_e                  master_mode,
  output logic [NUM_CH-1:0]             chan_en,
  output logic [PSC_W-1:0]              psc_act,
  output logic [CNT_W-1:0]              arr_act,
  output logic [NUM_CH-1:0][CNT_W-1:0]  cmp_act
);
  localparam int CTRL_W = CTRL_CHEN_LSB + NUM_CH;

  logic [CTRL_W-1:0] ctrl_q;
  logic [PSC_W-1:0]  psc_sh;
  logic [CNT_W-1:0]  arr_sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      psc_sh <= '0;
      arr_sh <= '0;
    end else if (cfg_we) begin
      if (cfg_addr == ADDR_W'(ADDR_CTRL)) ctrl_q <= cfg_wdata[CTRL_W-1:0];
      if (cfg_addr == ADDR_W'(ADDR_PSC))  psc_sh <= cfg_wdata[PSC_W-1:0];
      if (cfg_addr == ADDR_W'(ADDR_ARR))  arr_sh <= cfg_wdata[CNT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_act <= '0;
      arr_act <= '0;
    end else if (load_act) begin
      psc_act <= psc_sh;
      arr_act <= arr_sh;
    end
  end

  for (genvar k = 0; k < NUM_CH; k++) begin : g_cmp
    logic [CNT_W-1:0] cmp_sh;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cmp_sh     <= '0;
        cmp_act[k] <= '0;
      end else begin
        if (cfg_we && cfg_addr == ADDR_W'(ADDR_CMP_BASE + k))
          cmp_sh <= cfg_wdata[CNT_W-1:0];
        if (load_act)
          cmp_act[k] <= cmp_sh;
      end
    end
  end

  assign run_en      = ctrl_q[CTRL_RUN_BIT];
  assign slave_mode  = slave_mode_e'(ctrl_q[CTRL_SLV_LSB +: 2]);
  assign master_mode = master_mode_e'(ctrl_q[CTRL_MST_LSB +: 2]);
  assign chan_en     = ctrl_q[CTRL_CHEN_LSB +: NUM_CH];
endmodule

// File: rtl/cpt_time_base.sv
module cpt_time_base
  import cpt_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int PSC_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run_en,
  input  slave_mode_e      slave_mode,
  input  logic             gate_lvl,
  input  logic             trig_rise,
  input  logic [PSC_W-1:0] psc_act,
  input  logic [CNT_W-1:0] arr_act,
  output logic [CNT_W-1:0] cnt,
  output logic             wrap,
  output logic             upd,
  output logic             started,
  output logic             cnt_active
);
  logic [PSC_W-1:0] psc_cnt;
  logic             allowed;
  logic             int_step;
  logic             tick;

  always_comb begin
    unique case (slave_mode)
      SLV_GATED: allowed = gate_lvl;
      SLV_TRIG:  allowed = started;
      default:   allowed = 1'b1;
    endcase
  end

  assign cnt_active = run_en & allowed;
  assign int_step   = cnt_active & (slave_mode != SLV_EXTCLK);
  assign tick       = (slave_mode == SLV_EXTCLK) ? (run_en & trig_rise)
                                                 : (int_step & (psc_cnt == psc_act));
  assign wrap       = tick & (cnt == arr_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_cnt <= '0;
      cnt     <= '0;
      upd     <= 1'b0;
      started <= 1'b0;
    end else if (!run_en) begin
      psc_cnt <= '0;
      cnt     <= '0;
      upd     <= 1'b0;
      started <= 1'b0;
    end else begin
      if (int_step)
        psc_cnt <= (psc_cnt == psc_act) ? '0 : psc_cnt + 1'b1;
      if (tick)
        cnt <= wrap ? '0 : cnt + 1'b1;
      upd <= wrap;
      if (slave_mode == SLV_TRIG && trig_rise)
        started <= 1'b1;
    end
  end
endmodule

// File: rtl/cpt_pwm_chan.sv
module cpt_pwm_chan #(
  parameter int CNT_W = 16
) (
  input  logic [CNT_W-1:0] cnt,
  input  logic [CNT_W-1:0] cmp,
  input  logic             ref_allow,
  input  logic             out_allow,
  output logic             ref_o,
  output logic             pwm_o
);
  logic below;
  assign below = (cnt < cmp);
  assign ref_o = ref_allow & below;
  assign pwm_o = out_allow & below;
endmodule

// File: rtl/chain_pwm_timer.sv
module chain_pwm_timer
  import cpt_pkg::*;
#(
  parameter int  CNT_W  = 16,
  parameter int  NUM_CH = 4,
  parameter int  PSC_W  = 16,
  localparam int ADDR_W = $clog2(NUM_CH + ADDR_CMP_BASE)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cfg_we,
  input  logic [ADDR_W-1:0]     cfg_addr,
  input  logic [CFG_DATA_W-1:0] cfg_wdata,
  input  logic                  trig_in,
  output logic                  trig_out,
  output logic [NUM_CH-1:0]     pwm_out
);
  logic                         run_en;
  slave_mode_e                  slave_mode;
  master_mode_e                 master_mode;
  logic [NUM_CH-1:0]            chan_en;
  logic [PSC_W-1:0]             psc_act;
  logic [CNT_W-1:0]             arr_act;
  logic [NUM_CH-1:0][CNT_W-1:0] cmp_act;
  logic                         gate_lvl;
  logic                         trig_rise;
  logic [CNT_W-1:0]             cnt;
  logic                         wrap;
  logic                         upd;
  logic                         started;
  logic                         cnt_active;
  logic                         load_act;
  logic                         out_ok;
  logic [NUM_CH-1:0]            ref_w;

  assign load_act = wrap | ~run_en;

  cpt_trig_sync #(.STAGES(2)) sync_i (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in),
    .level(gate_lvl), .rise(trig_rise)
  );

  cpt_regfile #(.CNT_W(CNT_W), .PSC_W(PSC_W), .NUM_CH(NUM_CH), .ADDR_W(ADDR_W)) regs_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .load_act(load_act), .run_en(run_en),
    .slave_mode(slave_mode), .master_mode(master_mode), .chan_en(chan_en),
    .psc_act(psc_act), .arr_act(arr_act), .cmp_act(cmp_act)
  );

  cpt_time_base #(.CNT_W(CNT_W), .PSC_W(PSC_W)) tb_i (
    .clk(clk), .rst_n(rst_n), .run_en(run_en), .slave_mode(slave_mode),
    .gate_lvl(gate_lvl), .trig_rise(trig_rise), .psc_act(psc_act),
    .arr_act(arr_act), .cnt(cnt), .wrap(wrap), .upd(upd),
    .started(started), .cnt_active(cnt_active)
  );

  assign out_ok = cnt_active;

  for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
    cpt_pwm_chan #(.CNT_W(CNT_W)) ch_i (
      .cnt(cnt), .cmp(cmp_act[k]), .ref_allow(run_en),
      .out_allow(out_ok & chan_en[k]), .ref_o(ref_w[k]), .pwm_o(pwm_out[k])
    );
  end

  always_comb begin
    unique case (master_mode)
      MST_ENABLE: trig_out = cnt_active;
      MST_UPDATE: trig_out = upd;
      MST_CMP1:   trig_out = ref_w[0];
      default:    trig_out = 1'b0;
    endcase
  end
endmodule

// File: rtl/cpt_checker.sv
module cpt_checker
  import cpt_pkg::*;
#(
  parameter int CNT_W  = 16,
  parameter int NUM_CH = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              run_en,
  input logic [1:0]        slave_mode,
  input logic              gate_lvl,
  input logic              trig_rise,
  input logic              started,
  input logic [CNT_W-1:0]  cnt,
  input logic [CNT_W-1:0]  arr_act,
  input logic              upd,
  input logic [NUM_CH-1:0] pwm_out
);
  // R2
  cnt_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_en |-> cnt <= arr_act);

  // R2
  upd_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    upd |-> cnt == '0);

  // R5
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run_en |-> pwm_out == '0);

  // R7
  gated_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en && slave_mode == SLV_GATED && !gate_lvl) && run_en) |-> $stable(cnt));

  // R9
  ext_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en && slave_mode == SLV_EXTCLK && !trig_rise) && run_en) |-> $stable(cnt));

  // R8
  trig_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(run_en && slave_mode == SLV_TRIG && !started) && run_en) |-> $stable(cnt));
endmodule

bind chain_pwm_timer cpt_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) chk_i (
  .clk(clk), .rst_n(rst_n), .run_en(run_en), .slave_mode(slave_mode),
  .gate_lvl(gate_lvl), .trig_rise(trig_rise), .started(started),
  .cnt(cnt), .arr_act(arr_act), .upd(upd), .pwm_out(pwm_out)
);

// File: tb/chain_pwm_timer_tb_top.sv
module chain_pwm_timer_tb_top;
  localparam int CNT_W  = 32;
  localparam int NUM_CH = 4;
  localparam int PSC_W  = 16;
  localparam int AW     = 3;

  // rows: prescaler, reload, compare, expected high clocks per period
  localparam int NVEC = 5;
  localparam int VEC [NVEC][4] = '{
    '{0, 9, 5, 5},
    '{1, 9, 3, 6},
    '{0, 4, 0, 0},
    '{0, 4, 7, 5},
    '{2, 3, 4, 12}
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              cfg_we = 1'b0;
  logic [AW-1:0]     cfg_addr = '0;
  logic [31:0]       cfg_wdata = '0;
  logic              trig_in = 1'b0;
  logic              trig_out;
  logic [NUM_CH-1:0] pwm_out;

  int n_chk  = 0;
  int n_fail = 0;

  always #10 clk = ~clk;

  chain_pwm_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH), .PSC_W(PSC_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .trig_in(trig_in), .trig_out(trig_out),
    .pwm_out(pwm_out)
  );

  function automatic logic [31:0] ctrl(input int run, input int slv, input int mst, input int chen);
    return 32'(run | (slv << 1) | (mst << 3) | (chen << 5));
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr(input int addr, input logic [31:0] data);
    cfg_we    = 1'b1;
    cfg_addr  = AW'(addr);
    cfg_wdata = data;
    @(negedge clk);
    cfg_we    = 1'b0;
  endtask

  task automatic setup(input int p, input int a, input int c);
    wr(0, 32'd0);
    wr(1, 32'(p));
    wr(2, 32'(a));
    for (int k = 0; k < NUM_CH; k++) wr(3 + k, 32'(c));
  endtask

  task automatic measure(input int n, output int h0, output int h1, output int h3, output int tr);
    h0 = 0; h1 = 0; h3 = 0; tr = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (pwm_out[0]) h0++;
      if (pwm_out[1]) h1++;
      if (pwm_out[NUM_CH-1]) h3++;
      if (trig_out) tr++;
    end
  endtask

  task automatic finish_run;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int h0, h1, h3, tr, per, hA, hB, mism;
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 pwm after reset", int'(pwm_out), 0);
    chk("R1 trig after reset", int'(trig_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pwm after release", int'(pwm_out), 0);

    // vector table: free run, update pulses on trigger output
    for (int v = 0; v < NVEC; v++) begin
      per = (VEC[v][0] + 1) * (VEC[v][1] + 1);
      setup(VEC[v][0], VEC[v][1], VEC[v][2]);
      wr(0, ctrl(1, 0, 1, 4'hF));
      repeat (5) @(negedge clk);
      measure(4 * per, h0, h1, h3, tr);
      chk("R3/R12 ch0 high clocks", h0, 4 * VEC[v][3]);
      chk("R3 last channel high clocks", h3, 4 * VEC[v][3]);
      chk("R2 update pulses", tr, 4);
    end

    // R5: channel enable mask
    setup(0, 9, 5);
    wr(0, ctrl(1, 0, 0, 4'b1101));
    measure(40, h0, h1, h3, tr);
    chk("R5 masked channel", h1, 0);
    chk("R5 enabled channel", h0, 20);

    // R6: master selects channel-0 reference
    wr(0, ctrl(1, 0, 2, 4'hF));
    mism = 0;
    hA = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (trig_out != pwm_out[0]) mism++;
      if (trig_out) hA++;
    end
    chk("R6 cmp1 follows ch0", mism, 0);
    chk("R6 cmp1 high clocks", hA, 20);
    wr(0, ctrl(1, 0, 3, 4'hF));
    measure(20, h0, h1, h3, tr);
    chk("R6 mode 3 low", tr, 0);

    // R4: compare change lands at next update
    setup(0, 9, 5);
    wr(0, ctrl(1, 0, 1, 4'hF));
    while (!trig_out) @(negedge clk);
    hA = 0; hB = 0;
    for (int i = 0; i < 20; i++) begin
      if (pwm_out[0]) begin
        if (i < 10) hA++; else hB++;
      end
      if (i == 2) begin
        cfg_we = 1'b1; cfg_addr = AW'(3); cfg_wdata = 32'd8;
      end
      if (i == 3) cfg_we = 1'b0;
      @(negedge clk);
    end
    chk("R4 current period keeps old compare", hA, 5);
    chk("R4 next period uses new compare", hB, 8);

    // R7, R10: gated mode
    setup(0, 9, 5);
    trig_in = 1'b0;
    wr(0, ctrl(1, 1, 0, 4'hF));
    measure(30, h0, h1, h3, tr);
    chk("R7 gate closed no pulses", h0, 0);
    chk("R7 gate closed enable low", tr, 0);
    trig_in = 1'b1;
    @(negedge clk);
    chk("R10 one clock after gate rises", int'(trig_out), 0);
    @(negedge clk);
    chk("R10 two clocks after gate rises", int'(trig_out), 1);
    measure(40, h0, h1, h3, tr);
    chk("R7 gate open duty", h0, 20);
    trig_in = 1'b0;
    repeat (4) @(negedge clk);
    measure(30, h0, h1, h3, tr);
    chk("R7 gate closed again", h0, 0);

    // R9: external clock, prescaler ignored
    setup(5, 3, 2);
    wr(0, ctrl(1, 3, 0, 4'hF));
    h0 = 0;
    for (int i = 0; i < 80; i++) begin
      if (i >= 16 && pwm_out[0]) h0++;
      if (i % 4 == 0) trig_in = ~trig_in;
      @(negedge clk);
    end
    chk("R9 ext clock duty", h0, 32);

    // R8: trigger start
    trig_in = 1'b0;
    setup(0, 9, 5);
    repeat (4) @(negedge clk);
    wr(0, ctrl(1, 2, 0, 4'hF));
    measure(30, h0, h1, h3, tr);
    chk("R8 waiting no pulses", h0, 0);
    chk("R8 waiting enable low", tr, 0);
    trig_in = 1'b1;
    repeat (3) @(negedge clk);
    trig_in = 1'b0;
    repeat (3) @(negedge clk);
    chk("R8 started enable high", int'(trig_out), 1);
    measure(40, h0, h1, h3, tr);
    chk("R8 running duty", h0, 20);

    // R11: full-width reload and compare
    setup(0, 70000, 66000);
    wr(0, ctrl(1, 0, 1, 4'hF));
    repeat (2) @(negedge clk);
    measure(70001, h0, h1, h3, tr);
    chk("R11 wide compare", h0, 66000);
    chk("R11 wide period update", tr, 1);

    // R5: run bit clear forces outputs low
    wr(0, ctrl(0, 0, 0, 4'hF));
    measure(10, h0, h1, h3, tr);
    chk("R5 stopped outputs", h0 + h3, 0);

    finish_run();
  end
endmodule